// File: doc/BRIEF.md
# Swept-Sine Loop Response Analyzer

This block measures the frequency response of a closed digital control loop at one test frequency per run. It makes a sine tone from a phase accumulator and a quarter-wave lookup table, scales it, and adds it into the loop at a summing junction. The junction output drives the rest of the loop.

Two loop nodes are then correlated against in-phase and quadrature copies of the tone. The first is the junction output itself. The second is the loop output that comes back to the block. After a programmable settle period, the tone has driven the loop into steady state. The block then sums the four products over a programmable window. At the end of the window it latches the four sums and pulses `done`.

Software turns the four sums into amplitude and phase for each node. Ratios of these give the closed-loop response, the sensitivity function and the open-loop gain. Software repeats the run at several increments to build a Bode plot. The window should be set to a whole number of tone periods.

Top module: `swept_sine_analyzer`

## Requirements
- R1: After reset the block is as follows:
  - `busy` and `done` are 0.
  - All four results are 0.
  - `loop_drive` equals `loop_in`.
- R2: The tone is defined as follows:
  - The phase register is 32 bits and advances by `phase_inc` every cycle while `busy` is 1.
  - For phase p, let the 10-bit index be n = p[31:22]. The tone sample is round(32767·sin(2π(n+0.5)/1024)).
  - The injected value is floor(sample·`amp_scale`/65536).
  - While `busy` is 1, `loop_drive` is `loop_in` plus the injected value.
- R3: The junction sum saturates to the signed 16-bit range of −32768 to 32767.
- R4: While `busy` is 0, nothing is injected and `loop_drive` equals `loop_in`.
- R5: For settle length S, no products are accumulated during the first S cycles after the edge that takes `start`. S = 0 starts accumulation in the first cycle.
- R6: Products are accumulated for exactly W cycles, where W is `window_len`. A `window_len` of 0 acts as 1. The accumulators are 48-bit two's complement.
- R7: The four results are defined as follows:
  - `corr_sum_i` is the sum of `loop_drive`·sine.
  - `corr_sum_q` is the sum of `loop_drive`·cosine.
  - `corr_out_i` is the sum of `loop_out`·sine.
  - `corr_out_q` is the sum of `loop_out`·cosine.
  - The cosine is the tone sample at phase p + 2^30.
- R8: `done` and the results behave as follows:
  - `done` is high for exactly one cycle, in the cycle after the last window cycle.
  - In that same cycle `busy` is 0 and the results are updated.
  - The results hold until the next `done`.
- R9: A `start` taken while `busy` is 1 abandons the run in progress. The accumulators are cleared, and nothing from the abandoned run reaches the results.
- R10: Each `start` resets the phase to 0, so the first active cycle uses phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) a measurement |
| phase_inc | input | 32 | Tone phase increment per cycle |
| amp_scale | input | 16 | Unsigned tone amplitude scale, 65536 = full |
| settle_len | input | 32 | Settle cycles before accumulation |
| window_len | input | 32 | Accumulation cycles |
| loop_in | input | 16 | Signed loop signal entering the junction |
| loop_out | input | 16 | Signed loop output pick-off |
| loop_drive | output | 16 | Signed junction output, also the first pick-off |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle result-valid pulse |
| corr_sum_i | output | 48 | Junction output times sine |
| corr_sum_q | output | 48 | Junction output times cosine |
| corr_out_i | output | 48 | Loop output times sine |
| corr_out_q | output | 48 | Loop output times cosine |

## Verification
The bench runs several tests:
- A full-scale tone against random loop traffic. This checks the table, the scaling and the timing of all four sums together.
- A zero-scale run. Here the junction must pass `loop_in` unchanged while correlation still runs, which separates injection faults from correlation faults.
- Loop traffic pinned near the 16-bit limits. This shows whether the sum saturates or wraps.
- Zero settle with zero window. This tests the edge of the counters.
- A run abandoned mid-settle and then restarted. This shows whether the phase and the accumulators really clear.
- Randomly chosen frequencies, scales and lengths. These cover the remaining combinations.

// File: rtl/swept_sine_analyzer.sv
module swept_sine_analyzer #(
  parameter int DW     = 16,
  parameter int PW     = 32,
  parameter int LUT_AW = 8,
  parameter int SW     = 16,
  parameter int CW     = 32,
  parameter int AW     = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [PW-1:0]        phase_inc,
  input  logic [SW-1:0]        amp_scale,
  input  logic [CW-1:0]        settle_len,
  input  logic [CW-1:0]        window_len,
  input  logic signed [DW-1:0] loop_in,
  input  logic signed [DW-1:0] loop_out,
  output logic signed [DW-1:0] loop_drive,
  output logic                 busy,
  output logic                 done,
  output logic signed [AW-1:0] corr_sum_i,
  output logic signed [AW-1:0] corr_sum_q,
  output logic signed [AW-1:0] corr_out_i,
  output logic signed [AW-1:0] corr_out_q
);

  localparam int N    = 1 << LUT_AW;
  localparam int PMAX = (1 << (DW-1)) - 1;
  localparam int PRW  = 2*DW;

  typedef enum logic [1:0] {IDLE, SETTLE, MEAS} st_t;

  st_t                  state;
  logic [PW-1:0]        phase;
  logic [CW-1:0]        cnt;
  logic [DW-2:0]        qtab [N];
  logic signed [AW-1:0] acc [4];
  logic signed [AW-1:0] acc_nx [4];
  logic signed [AW-1:0] res [4];
  logic signed [PRW-1:0] prod [4];

  initial
    for (int i = 0; i < N; i++)
      qtab[i] = (DW-1)'($rtoi(real'(PMAX) *
                 $sin(3.14159265358979 / 2.0 * (real'(i) + 0.5) / real'(N)) + 0.5));

  function automatic logic signed [DW-1:0] wave(input logic [PW-1:0] p);
    logic [1:0]           q;
    logic [LUT_AW-1:0]    k;
    logic signed [DW-1:0] m;
    q = p[PW-1 -: 2];
    k = p[PW-3 -: LUT_AW];
    m = $signed({1'b0, qtab[q[0] ? ~k : k]});
    return q[1] ? -m : m;
  endfunction

  logic signed [DW-1:0]    sin_v, cos_v, stim, inj;
  logic signed [DW+SW:0]   sprod;
  logic signed [DW:0]      sum_w;

  assign sin_v = wave(phase);
  assign cos_v = wave(phase + (PW'(1) << (PW-2)));
  assign sprod = sin_v * $signed({1'b0, amp_scale});
  assign stim  = sprod[SW +: DW];
  assign busy  = (state != IDLE);
  assign inj   = busy ? stim : '0;
  assign sum_w = loop_in + inj;

  always_comb begin
    if (sum_w[DW] != sum_w[DW-1])
      loop_drive = sum_w[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else
      loop_drive = sum_w[DW-1:0];
  end

  assign prod[0] = loop_drive * sin_v;
  assign prod[1] = loop_drive * cos_v;
  assign prod[2] = loop_out   * sin_v;
  assign prod[3] = loop_out   * cos_v;

  for (genvar g = 0; g < 4; g++) begin : g_acc
    assign acc_nx[g] = acc[g] + {{(AW-PRW){prod[g][PRW-1]}}, prod[g]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      phase <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      for (int i = 0; i < 4; i++) begin
        acc[i] <= '0;
        res[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (start) begin
        phase <= '0;
        for (int i = 0; i < 4; i++) acc[i] <= '0;
        if (settle_len == '0) begin
          state <= MEAS;
          cnt   <= window_len;
        end else begin
          state <= SETTLE;
          cnt   <= settle_len;
        end
      end else begin
        case (state)
          SETTLE: begin
            phase <= phase + phase_inc;
            cnt   <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
              state <= MEAS;
              cnt   <= window_len;
            end
          end
          MEAS: begin
            phase <= phase + phase_inc;
            cnt   <= cnt - 1'b1;
            for (int i = 0; i < 4; i++) acc[i] <= acc_nx[i];
            if (cnt <= CW'(1)) begin
              for (int i = 0; i < 4; i++) res[i] <= acc_nx[i];
              done  <= 1'b1;
              state <= IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign corr_sum_i = res[0];
  assign corr_sum_q = res[1];
  assign corr_out_i = res[2];
  assign corr_out_q = res[3];

endmodule

// File: rtl/swept_sine_analyzer_chk.sv
module swept_sine_analyzer_chk #(
  parameter int DW = 16,
  parameter int AW = 48
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic signed [DW-1:0] loop_in,
  input logic signed [DW-1:0] loop_drive,
  input logic signed [AW-1:0] corr_sum_i,
  input logic signed [AW-1:0] corr_sum_q,
  input logic signed [AW-1:0] corr_out_i,
  input logic signed [AW-1:0] corr_out_q
);

  logic seen;
  always_ff @(posedge clk)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  p_no_inject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> loop_drive == loop_in);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !done) |-> ($stable(corr_sum_i) && $stable(corr_sum_q) &&
                         $stable(corr_out_i) && $stable(corr_out_q)));

endmodule

bind swept_sine_analyzer swept_sine_analyzer_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .loop_in(loop_in), .loop_drive(loop_drive),
  .corr_sum_i(corr_sum_i), .corr_sum_q(corr_sum_q),
  .corr_out_i(corr_out_i), .corr_out_q(corr_out_q)
);

// File: tb/swept_sine_analyzer_tb.sv
module swept_sine_analyzer_tb;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [31:0]        phase_inc = '0;
  logic [15:0]        amp_scale = '0;
  logic [31:0]        settle_len = '0;
  logic [31:0]        window_len = '0;
  logic signed [15:0] loop_in = '0;
  logic signed [15:0] loop_out = '0;
  logic signed [15:0] loop_drive;
  logic               busy, done;
  logic signed [47:0] corr_sum_i, corr_sum_q, corr_out_i, corr_out_q;

  int nchk = 0;
  int nfail = 0;
  bit m_busy = 1'b0;
  longint m_acc [4];

  always #2 clk = ~clk;

  swept_sine_analyzer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .phase_inc(phase_inc),
    .amp_scale(amp_scale), .settle_len(settle_len), .window_len(window_len),
    .loop_in(loop_in), .loop_out(loop_out), .loop_drive(loop_drive),
    .busy(busy), .done(done), .corr_sum_i(corr_sum_i), .corr_sum_q(corr_sum_q),
    .corr_out_i(corr_out_i), .corr_out_q(corr_out_q)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint tone(input logic [31:0] p);
    real v;
    v = 32767.0 * $sin(2.0 * 3.14159265358979 * (real'(p[31:22]) + 0.5) / 1024.0);
    return longint'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
  endfunction

  function automatic longint sat16(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic longint sx48(input longint x);
    return (x <<< 16) >>> 16;
  endfunction

  function automatic longint res(input int i);
    case (i)
      0: return longint'(corr_sum_i);
      1: return longint'(corr_sum_q);
      2: return longint'(corr_out_i);
      default: return longint'(corr_out_q);
    endcase
  endfunction

  task automatic drive_rand(input bit edge_mode);
    if (edge_mode) begin
      loop_in  = ($urandom % 2) ? 16'sd32767 - 16'($urandom % 64) : -16'sd32768 + 16'($urandom % 64);
      loop_out = 16'($urandom);
    end else begin
      loop_in  = 16'($urandom);
      loop_out = 16'($urandom);
    end
  endtask

  task automatic do_run(input logic [31:0] inc, input logic [15:0] sc, input int st,
                        input int wn, input int abort_at, input bit edge_mode);
    logic [31:0] ph;
    longint s, c, stim, sum, li, lo;
    int w, total;
    @(negedge clk);
    phase_inc = inc; amp_scale = sc; settle_len = st; window_len = wn; start = 1'b1;
    drive_rand(edge_mode);
    #1;
    if (!m_busy) chk(loop_drive == loop_in, "R4 idle pass-through", loop_drive, loop_in);
    @(negedge clk);
    start = 1'b0;
    m_busy = 1'b1;
    w = (wn == 0) ? 1 : wn;
    total = st + w;
    ph = '0;
    for (int i = 0; i < 4; i++) m_acc[i] = 0;
    for (int j = 0; j < total; j++) begin
      if (j > 0) @(negedge clk);
      drive_rand(edge_mode);
      #1;
      li = longint'(loop_in);
      lo = longint'(loop_out);
      s = tone(ph);
      c = tone(ph + 32'h4000_0000);
      stim = (s * longint'(sc)) >>> 16;
      sum = sat16(li + stim);
      if (li + stim != sum)
        chk(longint'(loop_drive) == sum, "R3 saturated sum", loop_drive, sum);
      else
        chk(longint'(loop_drive) == sum, "R2 R10 injected sum", loop_drive, sum);
      chk(busy == 1'b1 && done == 1'b0, "R5 R6 busy without done", {busy, done}, 2);
      if (j >= st) begin
        m_acc[0] += sum * s;
        m_acc[1] += sum * c;
        m_acc[2] += lo * s;
        m_acc[3] += lo * c;
      end
      if (j == abort_at) return;
      ph = ph + inc;
    end
    @(negedge clk);
    #1;
    m_busy = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R8 done pulse", {done, busy}, 2);
    for (int i = 0; i < 4; i++)
      chk(res(i) == sx48(m_acc[i]), "R5 R6 R7 R9 correlation result", res(i), sx48(m_acc[i]));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      drive_rand(1'b0);
      #1;
      chk(done == 1'b0, "R8 single-cycle done", done, 0);
      chk(loop_drive == loop_in, "R4 no injection when idle", loop_drive, loop_in);
      chk(res(2) == sx48(m_acc[2]), "R8 result hold", res(2), sx48(m_acc[2]));
    end
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    @(negedge clk);
    loop_in = 16'sd1234;
    #1;
    chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", {busy, done}, 0);
    chk(loop_drive == loop_in, "R1 reset pass-through", loop_drive, loop_in);
    chk(corr_sum_i == 0 && corr_sum_q == 0 && corr_out_i == 0 && corr_out_q == 0,
        "R1 reset results", corr_sum_i, 0);
    rst_n = 1'b1;
    do_run(32'h0400_0000, 16'hFFFF, 10, 128, -1, 1'b0);
    do_run(32'h0123_4567, 16'h0000, 5, 40, -1, 1'b0);
    do_run(32'h0800_0000, 16'h8000, 0, 0, -1, 1'b0);
    do_run(32'h0200_0000, 16'hFFFF, 3, 200, -1, 1'b1);
    do_run(32'h0100_0000, 16'h4000, 20, 50, 7, 1'b0);
    do_run(32'h0100_0000, 16'h4000, 4, 64, -1, 1'b0);
    do_run(32'h0100_0000, 16'h4000, 2, 30, 25, 1'b0);
    do_run(32'h0333_0000, 16'h7000, 6, 33, -1, 1'b0);
    for (int r = 0; r < 10; r++)
      do_run($urandom, 16'($urandom), int'($urandom % 20), int'($urandom % 150), -1, r[0]);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule